// File: doc/BRIEF.md
# Dual-Width Unsigned Divider

This block divides unsigned integers over several clock cycles, in one of two widths chosen when an operation starts. In half-width mode (16 bits by default) the dividend and divisor are each a single low word. The quotient and remainder come back on the low quotient and low remainder outputs. In full-width mode the dividend and the divisor are each formed from a high word and a low word. The 32-bit quotient and 32-bit remainder are split the same way across the high and low outputs.

A zero divisor does not raise an error. The quotient becomes all ones and the remainder equals the dividend. Each mode has one fixed latency whatever the operands, so a controller upstream can schedule around the divider without waiting on a handshake.

Internally a controller moves through three named states. `ST_IDLE` waits for `start`. `ST_RUN` performs two restoring-division steps per cycle, and `ST_FIN` registers the results and raises `done`. The transitions are:
- IDLE→RUN, when `start` is sampled high.
- RUN→RUN, while iterations remain.
- RUN→FIN, on the last iteration.
- FIN→IDLE, unconditionally.

Top module: `udiv_dual`

## Requirements
- R1: With `wide`=0 and a nonzero `dvs_lo`, the operation returns `dvd_lo / dvs_lo` on `quo_lo` and `dvd_lo % dvs_lo` on `rem_lo`. The inputs `dvd_hi` and `dvs_hi` have no effect.
- R2: With `wide`=1 and a nonzero {`dvs_hi`,`dvs_lo`}, the dividend is {`dvd_hi`,`dvd_lo`}, with the high word in the upper 16 bits. The quotient appears as {`quo_hi`,`quo_lo`} and the remainder as {`rem_hi`,`rem_lo`}. A divisor whose low word is zero but whose high word is not counts as nonzero.
- R3: With `wide`=0 and `dvs_lo`=0, the result is `quo_lo`=16'hFFFF and `rem_lo`=`dvd_lo`.
- R4: With `wide`=1 and both divisor words zero, the result is `quo_hi`=`quo_lo`=16'hFFFF, `rem_lo`=`dvd_lo` and `rem_hi`=`dvd_hi`.
- R5: The divider accepts `start` at clock edge k. `done` is then high in the cycle after edge k+9 in half-width mode and after edge k+17 in full-width mode. A zero divisor does not change this timing.
- R6: `done` is high for exactly one cycle per accepted operation.
- R7: The divider ignores `start` from the accepting edge up to and including the edge at which `done` rises. Operand and mode inputs are sampled only at the accepting edge, so later changes to them do not affect the result.
- R8: Result outputs change only at the edge where `done` rises, and they hold their values until the next completion.
- R9: A half-width operation leaves `quo_hi` and `rem_hi` unchanged.
- R10: While `rst_n` is low, `done` and all four result outputs are 0 and no operation is in progress.
- R11: A `start` sampled in the cycle where `done` is high is accepted. With `start` held high continuously, half-width operations therefore complete every 10 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| wide | input | 1 | Mode select: 0 = half width, 1 = full width |
| dvd_lo | input | 16 | Dividend low word |
| dvd_hi | input | 16 | Dividend high word (full-width mode only) |
| dvs_lo | input | 16 | Divisor low word |
| dvs_hi | input | 16 | Divisor high word (full-width mode only) |
| quo_lo | output | 16 | Quotient low word |
| quo_hi | output | 16 | Quotient high word |
| rem_lo | output | 16 | Remainder low word |
| rem_hi | output | 16 | Remainder high word |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: completion of one operation (the `ST_FIN` edge and the `done` cycle that follows it) and a fresh `start` request. The bench provokes this by pulsing `start` at random through each operation and by holding `start` high across several operations. A request at the finishing edge must be dropped, and a request during the `done` cycle must begin a new operation. A behavioural model sets the expected `done` timing and result words for every cycle, and the bench compares the outputs against it each cycle.

// File: rtl/udiv_pkg.sv
package udiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } udiv_state_e;

    localparam logic MODE_HALF = 1'b0;
    localparam logic MODE_FULL = 1'b1;

endpackage

// File: rtl/udiv_step.sv
// One restoring division step: shift one dividend bit into the partial
// remainder and subtract the divisor when it fits.
module udiv_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_in,
    input  logic         bit_in,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] rem_out,
    output logic         q_bit
);

    logic [W:0]   trial;
    logic [W-1:0] diff;

    always_comb begin
        trial   = {rem_in, bit_in};
        // Modular difference is exact whenever the divisor fits.
        diff    = trial[W-1:0] - dvs;
        q_bit   = (trial >= {1'b0, dvs});
        rem_out = q_bit ? diff : trial[W-1:0];
    end

endmodule

// File: rtl/udiv_ctrl.sv
module udiv_ctrl
    import udiv_pkg::*;
#(
    parameter int NARROW_ITERS = 8,
    parameter int WIDE_ITERS   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic wide,
    output logic load,
    output logic step_en,
    output logic finish
);

    localparam int CW = $clog2(WIDE_ITERS + 1);

    udiv_state_e    state, nstate;
    logic [CW-1:0]  iter_left;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nstate;
        end
    end

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: if (start) nstate = ST_RUN;
            ST_RUN:  if (iter_left == CW'(1)) nstate = ST_FIN;
            ST_FIN:  nstate = ST_IDLE;
            default: nstate = ST_IDLE;
        endcase
    end

    // Iteration counter, loaded per mode on acceptance.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iter_left <= '0;
        end else if (load) begin
            iter_left <= (wide == MODE_FULL) ? CW'(WIDE_ITERS) : CW'(NARROW_ITERS);
        end else if (step_en) begin
            iter_left <= iter_left - CW'(1);
        end
    end

    // Outputs.
    always_comb begin
        load    = 1'b0;
        step_en = 1'b0;
        finish  = 1'b0;
        unique case (state)
            ST_IDLE: load    = start;
            ST_RUN:  step_en = 1'b1;
            ST_FIN:  finish  = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/udiv_core.sv
module udiv_core
    import udiv_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int STEPS  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  step_en,
    input  logic                  wide,
    input  logic [HALF_W-1:0]     dvd_lo,
    input  logic [HALF_W-1:0]     dvd_hi,
    input  logic [HALF_W-1:0]     dvs_lo,
    input  logic [HALF_W-1:0]     dvs_hi,
    output logic [2*HALF_W-1:0]   quo_acc,
    output logic [2*HALF_W-1:0]   rem_acc,
    output logic                  zero_dvs,
    output logic                  wide_r
);

    localparam int FULL_W = 2 * HALF_W;

    logic [FULL_W-1:0]            dvs_r;
    logic [FULL_W-1:0]            dvs_load;
    logic [STEPS:0][FULL_W-1:0]   rem_chain;
    logic [STEPS:0][FULL_W-1:0]   quo_chain;
    logic [STEPS-1:0]             qb;

    assign dvs_load     = (wide == MODE_FULL) ? {dvs_hi, dvs_lo}
                                              : {{HALF_W{1'b0}}, dvs_lo};
    assign rem_chain[0] = rem_acc;
    assign quo_chain[0] = quo_acc;

    for (genvar g = 0; g < STEPS; g++) begin : g_step
        udiv_step #(.W(FULL_W)) u_step (
            .rem_in  (rem_chain[g]),
            .bit_in  (quo_chain[g][FULL_W-1]),
            .dvs     (dvs_r),
            .rem_out (rem_chain[g+1]),
            .q_bit   (qb[g])
        );
        assign quo_chain[g+1] = {quo_chain[g][FULL_W-2:0], qb[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo_acc  <= '0;
            rem_acc  <= '0;
            dvs_r    <= '0;
            zero_dvs <= 1'b0;
            wide_r   <= MODE_HALF;
        end else if (load) begin
            rem_acc  <= '0;
            // Half-width dividends are left-justified so that the same
            // shift path serves both modes.
            quo_acc  <= (wide == MODE_FULL) ? {dvd_hi, dvd_lo}
                                            : {dvd_lo, {HALF_W{1'b0}}};
            dvs_r    <= dvs_load;
            zero_dvs <= (dvs_load == '0);
            wide_r   <= wide;
        end else if (step_en) begin
            quo_acc  <= quo_chain[STEPS];
            rem_acc  <= rem_chain[STEPS];
        end
    end

endmodule

// File: rtl/udiv_dual.sv
module udiv_dual
    import udiv_pkg::*;
#(
    parameter int HALF_W          = 16,
    parameter int STEPS_PER_CYCLE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wide,
    input  logic [HALF_W-1:0] dvd_lo,
    input  logic [HALF_W-1:0] dvd_hi,
    input  logic [HALF_W-1:0] dvs_lo,
    input  logic [HALF_W-1:0] dvs_hi,
    output logic [HALF_W-1:0] quo_lo,
    output logic [HALF_W-1:0] quo_hi,
    output logic [HALF_W-1:0] rem_lo,
    output logic [HALF_W-1:0] rem_hi,
    output logic              done
);

    localparam int FULL_W       = 2 * HALF_W;
    localparam int NARROW_ITERS = HALF_W / STEPS_PER_CYCLE;
    localparam int WIDE_ITERS   = FULL_W / STEPS_PER_CYCLE;

    logic              load, step_en, finish;
    logic [FULL_W-1:0] quo_acc, rem_acc;
    logic              zero_dvs, wide_r;

    udiv_ctrl #(
        .NARROW_ITERS (NARROW_ITERS),
        .WIDE_ITERS   (WIDE_ITERS)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .wide    (wide),
        .load    (load),
        .step_en (step_en),
        .finish  (finish)
    );

    udiv_core #(
        .HALF_W (HALF_W),
        .STEPS  (STEPS_PER_CYCLE)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step_en  (step_en),
        .wide     (wide),
        .dvd_lo   (dvd_lo),
        .dvd_hi   (dvd_hi),
        .dvs_lo   (dvs_lo),
        .dvs_hi   (dvs_hi),
        .quo_acc  (quo_acc),
        .rem_acc  (rem_acc),
        .zero_dvs (zero_dvs),
        .wide_r   (wide_r)
    );

    // Result registers: written once per operation, at the finishing edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo_lo <= '0;
            quo_hi <= '0;
            rem_lo <= '0;
            rem_hi <= '0;
            done   <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                quo_lo <= zero_dvs ? {HALF_W{1'b1}} : quo_acc[HALF_W-1:0];
                rem_lo <= rem_acc[HALF_W-1:0];
                if (wide_r == MODE_FULL) begin
                    quo_hi <= zero_dvs ? {HALF_W{1'b1}} : quo_acc[FULL_W-1:HALF_W];
                    rem_hi <= rem_acc[FULL_W-1:HALF_W];
                end
            end
        end
    end

endmodule

// File: rtl/udiv_dual_chk.sv
module udiv_dual_chk #(
    parameter int HALF_W          = 16,
    parameter int STEPS_PER_CYCLE = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              wide,
    input logic [HALF_W-1:0] dvd_lo,
    input logic [HALF_W-1:0] dvd_hi,
    input logic [HALF_W-1:0] dvs_lo,
    input logic [HALF_W-1:0] dvs_hi,
    input logic [HALF_W-1:0] quo_lo,
    input logic [HALF_W-1:0] quo_hi,
    input logic [HALF_W-1:0] rem_lo,
    input logic [HALF_W-1:0] rem_hi,
    input logic              done
);

    localparam int FULL_W     = 2 * HALF_W;
    localparam int NARROW_LAT = HALF_W / STEPS_PER_CYCLE + 1;
    localparam int WIDE_LAT   = FULL_W / STEPS_PER_CYCLE + 1;

    logic              busy_m, wide_m;
    int                age_m, lat_m;
    logic [FULL_W-1:0] n_m, d_m;
    logic              fin_m;
    logic [FULL_W-1:0] q_obs, r_obs;
    logic [2*FULL_W-1:0] recon;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_m <= 1'b0;
            wide_m <= 1'b0;
            age_m  <= 0;
            lat_m  <= 0;
            n_m    <= '0;
            d_m    <= '0;
        end else if (busy_m) begin
            if (age_m + 1 == lat_m) busy_m <= 1'b0;
            age_m <= age_m + 1;
        end else if (start) begin
            busy_m <= 1'b1;
            age_m  <= 0;
            wide_m <= wide;
            lat_m  <= wide ? WIDE_LAT : NARROW_LAT;
            n_m    <= wide ? {dvd_hi, dvd_lo} : {{HALF_W{1'b0}}, dvd_lo};
            d_m    <= wide ? {dvs_hi, dvs_lo} : {{HALF_W{1'b0}}, dvs_lo};
        end
    end

    always_comb begin
        fin_m = busy_m && (age_m + 1 == lat_m);
        q_obs = wide_m ? {quo_hi, quo_lo} : {{HALF_W{1'b0}}, quo_lo};
        r_obs = wide_m ? {rem_hi, rem_lo} : {{HALF_W{1'b0}}, rem_lo};
        recon = (2*FULL_W)'(q_obs) * (2*FULL_W)'(d_m) + (2*FULL_W)'(r_obs);
    end

    AST_DONE_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n) fin_m |=> done); // R5
    AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n) !fin_m |=> !done); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable({quo_lo, quo_hi, rem_lo, rem_hi})); // R8
    AST_HALF_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n) (done && !wide_m) |-> $stable({quo_hi, rem_hi})); // R9
    AST_DIV_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n) (done && d_m != '0) |-> (recon == (2*FULL_W)'(n_m) && r_obs < d_m)); // R1
    AST_HALF_ZERO_DVS: assert property (@(posedge clk) disable iff (!rst_n) (done && !wide_m && d_m == '0) |-> (quo_lo == {HALF_W{1'b1}} && rem_lo == n_m[HALF_W-1:0])); // R3
    AST_FULL_ZERO_DVS: assert property (@(posedge clk) disable iff (!rst_n) (done && wide_m && d_m == '0) |-> ({quo_hi, quo_lo} == {FULL_W{1'b1}} && {rem_hi, rem_lo} == n_m)); // R4

endmodule

bind udiv_dual udiv_dual_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .wide   (wide),
    .dvd_lo (dvd_lo),
    .dvd_hi (dvd_hi),
    .dvs_lo (dvs_lo),
    .dvs_hi (dvs_hi),
    .quo_lo (quo_lo),
    .quo_hi (quo_hi),
    .rem_lo (rem_lo),
    .rem_hi (rem_hi),
    .done   (done)
);

// File: tb/udiv_dual_test.sv
module udiv_dual_test;

    logic        clk = 1'b0;
    logic        rst_n, start, wide;
    logic [15:0] a_lo, a_hi, b_lo, b_hi;
    logic [15:0] q_lo, q_hi, r_lo, r_hi;
    logic        done;

    always #5 clk = ~clk;

    udiv_dual uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .wide   (wide),
        .dvd_lo (a_lo),
        .dvd_hi (a_hi),
        .dvs_lo (b_lo),
        .dvs_hi (b_hi),
        .quo_lo (q_lo),
        .quo_hi (q_hi),
        .rem_lo (r_lo),
        .rem_hi (r_hi),
        .done   (done)
    );

    int    total = 0;
    int    bad   = 0;
    string cur_req = "R10";
    bit    checking = 1'b0;

    // Behavioural reference model, advanced on every rising edge.
    bit              m_busy = 1'b0;
    int              m_age = 0;
    int              m_lat = 0;
    bit              m_wide = 1'b0;
    longint unsigned m_n = 0, m_d = 0, m_q, m_r;
    logic [15:0]     e_qlo = '0, e_qhi = '0, e_rlo = '0, e_rhi = '0;
    bit              e_done = 1'b0;

    always @(posedge clk) begin
        e_done = 1'b0;
        if (!rst_n) begin
            m_busy = 1'b0;
            m_age  = 0;
            e_qlo = '0; e_qhi = '0; e_rlo = '0; e_rhi = '0;
        end else if (m_busy) begin
            m_age++;
            if (m_age == m_lat) begin
                m_busy = 1'b0;
                e_done = 1'b1;
                if (m_d == 0) begin
                    m_q = m_wide ? 64'hFFFF_FFFF : 64'hFFFF;
                    m_r = m_n;
                end else begin
                    m_q = m_n / m_d;
                    m_r = m_n % m_d;
                end
                e_qlo = m_q[15:0];
                e_rlo = m_r[15:0];
                if (m_wide) begin
                    e_qhi = m_q[31:16];
                    e_rhi = m_r[31:16];
                end
            end
        end else if (start) begin
            m_busy = 1'b1;
            m_age  = 0;
            m_wide = wide;
            m_lat  = wide ? 17 : 9;
            m_n    = wide ? {32'd0, a_hi, a_lo} : {48'd0, a_lo};
            m_d    = wide ? {32'd0, b_hi, b_lo} : {48'd0, b_lo};
        end
    end

    always @(negedge clk) begin
        if (checking) begin
            total++;
            if ({done, q_lo, q_hi, r_lo, r_hi} !== {e_done, e_qlo, e_qhi, e_rlo, e_rhi}) begin
                bad++;
                $display("FAIL %s: done=%0b q=%h_%h r=%h_%h expected done=%0b q=%h_%h r=%h_%h",
                         cur_req, done, q_hi, q_lo, r_hi, r_lo,
                         e_done, e_qhi, e_qlo, e_rhi, e_rlo);
            end
        end
    end

    task automatic chk(input string req, input bit ok, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One operation; optional random start pulses while it is in flight.
    task automatic run(input bit w, input logic [15:0] alo, input logic [15:0] ahi,
                       input logic [15:0] blo, input logic [15:0] bhi,
                       input int exp_lat, input bit noise);
        int cyc;
        @(negedge clk);
        start = 1'b1; wide = w;
        a_lo = alo; a_hi = ahi; b_lo = blo; b_hi = bhi;
        @(negedge clk);
        start = 1'b0;
        // R7: operands after the accepting edge must not matter
        a_lo = 16'($urandom); a_hi = 16'($urandom);
        b_lo = 16'($urandom); b_hi = 16'($urandom);
        wide = 1'($urandom);
        cyc = 1;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
            start = (noise && !done) ? 1'($urandom) : 1'b0;
        end
        start = 1'b0;
        chk("R5 latency", (cyc - 1) == exp_lat, cyc - 1, exp_lat);
        @(negedge clk);
        chk("R6 done width", done == 1'b0, done, 0);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=hung expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] keep_qhi, keep_rhi;
        int n_done;
        rst_n = 1'b0; start = 1'b0; wide = 1'b0;
        a_lo = '0; a_hi = '0; b_lo = '0; b_hi = '0;
        @(posedge clk);
        @(negedge clk);
        checking = 1'b1;

        // R10: reset state, with start requested during reset
        start = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 reset", {done, q_lo, q_hi, r_lo, r_hi} == '0, {done, q_lo}, 0);
        start = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 idle after reset", done == 1'b0, done, 0);

        cur_req = "R1";
        run(1'b0, 16'd1000,  16'hDEAD, 16'd7,     16'hBEEF, 9, 1'b0);
        chk("R1 quotient", q_lo == 16'd142, q_lo, 142);
        chk("R1 remainder", r_lo == 16'd6, r_lo, 6);
        run(1'b0, 16'hFFFF, 16'h1234, 16'd1,     16'h0000, 9, 1'b0);
        run(1'b0, 16'd5,    16'h0000, 16'd9,     16'h5555, 9, 1'b0);
        run(1'b0, 16'hFFFF, 16'h0000, 16'hFFFF,  16'h0000, 9, 1'b0);

        cur_req = "R3";
        run(1'b0, 16'hA5C3, 16'h7777, 16'd0,     16'h9999, 9, 1'b0);
        chk("R3 zero quotient", q_lo == 16'hFFFF, q_lo, 16'hFFFF);
        chk("R3 zero remainder", r_lo == 16'hA5C3, r_lo, 16'hA5C3);

        cur_req = "R2";
        run(1'b1, 16'h5678, 16'h1234, 16'h1234, 16'h0000, 17, 1'b0);
        run(1'b1, 16'hFFFF, 16'hFFFF, 16'd3,    16'h0000, 17, 1'b0);
        chk("R2 quotient", {q_hi, q_lo} == 32'h5555_5555, {q_hi, q_lo}, 32'h5555_5555);
        run(1'b1, 16'h0000, 16'h8000, 16'h0000, 16'h0001, 17, 1'b0);
        chk("R2 high-word divisor", {q_hi, q_lo} == 32'h0000_8000, {q_hi, q_lo}, 32'h8000);
        run(1'b1, 16'h0010, 16'h0000, 16'h0000, 16'h0002, 17, 1'b0);

        cur_req = "R4";
        run(1'b1, 16'h3C3C, 16'hC001, 16'h0000, 16'h0000, 17, 1'b0);
        chk("R4 zero quotient", {q_hi, q_lo} == 32'hFFFF_FFFF, {q_hi, q_lo}, 32'hFFFF_FFFF);
        chk("R4 zero remainder", {r_hi, r_lo} == 32'hC001_3C3C, {r_hi, r_lo}, 32'hC001_3C3C);

        cur_req = "R9";
        keep_qhi = q_hi; keep_rhi = r_hi;
        run(1'b0, 16'd200, 16'h0F0F, 16'd0, 16'h0101, 9, 1'b0);
        chk("R9 quo_hi kept", q_hi == keep_qhi, q_hi, keep_qhi);
        chk("R9 rem_hi kept", r_hi == keep_rhi, r_hi, keep_rhi);

        cur_req = "R8";
        keep_qhi = q_lo;
        repeat (12) @(negedge clk);
        chk("R8 result held", q_lo == keep_qhi, q_lo, keep_qhi);

        cur_req = "R7";
        for (int i = 0; i < 6; i++) begin
            run(1'(i % 2), 16'($urandom), 16'($urandom), 16'($urandom % 300),
                16'(i % 3 == 0 ? 0 : $urandom % 4), (i % 2) ? 17 : 9, 1'b1);
        end

        cur_req = "R11";
        @(negedge clk);
        start = 1'b1; wide = 1'b0; a_lo = 16'd100; b_lo = 16'd3;
        n_done = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (done) n_done++;
        end
        start = 1'b0;
        chk("R11 back-to-back completions", n_done == 3, n_done, 3);
        repeat (20) @(negedge clk);

        checking = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule